// File: doc/BRIEF.md
# Manchester Line Decoder with Nibble Output

This block takes a 10 Mb/s Manchester-coded receive line and turns it into 4-bit words for a media-access controller. The line is sampled by a system clock that runs at `OSR` times the bit rate (8 by default, so 80 MHz). The block first hunts for the frame preamble. The preamble is a run of bits that alternate 1 and 0, which gives evenly spaced transitions of alternating direction at the middle of each bit. After enough of these transitions the block locks. While locked it treats each transition that falls near the expected centre of a bit as that bit's value, and it ignores the transitions that fall on bit boundaries.

Decoded bits are packed into nibbles. The first bit received goes into bit 0. Each completed nibble appears with a one-cycle strobe, so at the nominal line rate nibbles arrive every `4*OSR` cycles, which is 2.5 MHz. The receive-valid output stays high while the block is locked. When the mid-bit transitions stop, the block declares end of frame: valid falls, any partly filled nibble is thrown away, and the block goes back to hunting for the next preamble.

Top module: `mdec_rx`

## Requirements
- R1: After reset, `rx_dv`, `nib_stb` and `nib_data` are all zero.
- R2: A logic 1 is a low-to-high transition at the middle of the bit, and a logic 0 is a high-to-low transition there. The line is sampled `OSR` times per bit.
- R3: Lock is reached only after `PRE_EDGES` (16) consecutive transitions in which each is 6 to 10 samples after the one before and opposite in direction to it. Until then `rx_dv` stays 0 and no nibble is produced. A preamble that is too short, or a run of equal bits, does not lock.
- R4: When lock is reached, `rx_dv` goes to 1. The first bit delivered is the one whose mid-bit transition comes after the locking transition, which is zero-based bit index `PRE_EDGES` of the frame.
- R5: While locked, a transition that arrives less than 3/4 of a bit time (6 samples) after the last mid-bit transition is treated as a bit boundary and ignored.
- R6: Every 4 delivered bits form one nibble, with the earliest bit in `nib_data[0]`. `nib_stb` is high for one cycle while `nib_data` holds that nibble.
- R7: Within a frame, consecutive `nib_stb` pulses are at least `4*(OSR-OSR/4)` cycles apart. At the nominal rate they are exactly `4*OSR` cycles apart.
- R8: If no mid-bit transition arrives within 1.5 bit times (12 samples) of the last one, `rx_dv` falls and any partial nibble is discarded without a strobe.
- R9: After an end of frame, a new preamble locks again and decodes the next frame in the same way.
- R10: `nib_stb` is never high while `rx_dv` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sampling clock, `OSR` times the bit rate |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_line | input | 1 | Manchester-coded receive line; its idle level is low |
| rx_dv | output | 1 | High while bit timing is locked to a frame |
| nib_stb | output | 1 | One-cycle strobe marking a new nibble |
| nib_data | output | NIB_W | Decoded nibble, earliest bit in bit 0 |

## Verification
The assertions assume the following about the input. Bit-centre transitions arrive between 3/4 and 3/2 of a bit time apart. Bit-boundary transitions arrive about half a bit after a centre transition. The line idles low between frames. Under these conditions, a locked state never holds a silent gap of 12 samples, and nibble strobes cannot come closer than 24 cycles. The stimulus stays inside these conditions by driving every half bit as exactly `OSR/2` clock cycles, starting each frame from the low idle level, and leaving at least five bit times of idle between frames. Even so, it includes a short preamble and a run of equal bits, so that the hunting logic sees legal but non-locking patterns.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
    typedef enum logic {
        MODE_HUNT = 1'b0,
        MODE_LOCK = 1'b1
    } mdec_mode_e;
endpackage

// File: rtl/mdec_edge.sv
module mdec_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic line_i,
    output logic edge_o,
    output logic level_o
);
    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              prev;
    } edge_st_t;

    edge_st_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.sync = {s_q.sync[STAGES-2:0], line_i};
        s_d.prev = s_q.sync[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign level_o = s_q.sync[STAGES-1];
    assign edge_o  = s_q.sync[STAGES-1] ^ s_q.prev;
endmodule

// File: rtl/mdec_bitrec.sv
module mdec_bitrec
    import mdec_pkg::*;
#(
    parameter int OSR       = 8,
    parameter int PRE_EDGES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic edge_i,
    input  logic level_i,
    output logic locked_o,
    output logic bit_stb_o,
    output logic bit_o
);
    localparam int WIN_LO = OSR - OSR / 4;
    localparam int WIN_HI = OSR + OSR / 4;
    localparam int TMO    = OSR + OSR / 2;
    localparam int GW     = $clog2(TMO + 2);
    localparam int CW     = $clog2(PRE_EDGES + 1);

    typedef struct packed {
        mdec_mode_e    mode;
        logic [GW-1:0] gap;
        logic [CW-1:0] cnt;
        logic          dir;
        logic          stb;
        logic          val;
    } rec_st_t;

    rec_st_t r_d, r_q;
    logic [GW-1:0] elapsed;

    always_comb begin
        r_d     = r_q;
        r_d.stb = 1'b0;
        elapsed = r_q.gap + 1'b1;
        if (r_q.gap < GW'(TMO)) r_d.gap = elapsed;
        if (r_q.mode == MODE_HUNT) begin
            if (edge_i) begin
                r_d.gap = '0;
                r_d.dir = level_i;
                if (r_q.cnt != '0 && elapsed >= GW'(WIN_LO) &&
                    elapsed <= GW'(WIN_HI) && level_i != r_q.dir) begin
                    if (r_q.cnt == CW'(PRE_EDGES - 1)) begin
                        r_d.mode = MODE_LOCK;
                        r_d.cnt  = '0;
                    end else begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end
                end else begin
                    r_d.cnt = CW'(1);
                end
            end else if (elapsed > GW'(WIN_HI)) begin
                r_d.cnt = '0;
            end
        end else begin
            if (edge_i && elapsed >= GW'(WIN_LO)) begin
                r_d.gap = '0;
                r_d.stb = 1'b1;
                r_d.val = level_i;
            end else if (elapsed >= GW'(TMO)) begin
                r_d.mode = MODE_HUNT;
                r_d.cnt  = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.mode <= MODE_HUNT;
        end else begin
            r_q <= r_d;
        end
    end

    assign locked_o  = (r_q.mode == MODE_LOCK);
    assign bit_stb_o = r_q.stb;
    assign bit_o     = r_q.val;

    // R3
    lock_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked_o) |-> $past(edge_i));

    // R8
    gap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked_o |-> (r_q.gap < GW'(TMO)));
endmodule

// File: rtl/mdec_nibble.sv
module mdec_nibble #(
    parameter int W       = 4,
    parameter int MIN_GAP = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         active_i,
    input  logic         bit_stb_i,
    input  logic         bit_i,
    output logic         nib_stb_o,
    output logic [W-1:0] nib_o
);
    localparam int IW = $clog2(W);
    localparam int SW = $clog2(MIN_GAP + 1);

    typedef struct packed {
        logic [W-1:0]  sh;
        logic [IW-1:0] idx;
        logic          stb;
        logic [W-1:0]  data;
    } nib_st_t;

    nib_st_t n_d, n_q;
    logic [W-1:0] merged;

    always_comb begin
        n_d         = n_q;
        n_d.stb     = 1'b0;
        merged      = n_q.sh;
        merged[n_q.idx] = bit_i;
        if (!active_i) begin
            n_d.idx = '0;
        end else if (bit_stb_i) begin
            n_d.sh = merged;
            if (n_q.idx == IW'(W - 1)) begin
                n_d.idx  = '0;
                n_d.stb  = 1'b1;
                n_d.data = merged;
            end else begin
                n_d.idx = n_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) n_q <= '0;
        else        n_q <= n_d;
    end

    assign nib_stb_o = n_q.stb;
    assign nib_o     = n_q.data;

    logic [SW-1:0] since_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                         since_q <= SW'(MIN_GAP);
        else if (nib_stb_o)                 since_q <= '0;
        else if (since_q < SW'(MIN_GAP))    since_q <= since_q + 1'b1;
    end

    // R7
    stb_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb_o |-> (since_q >= SW'(MIN_GAP - 1)));

    // R8
    no_partial_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> !nib_stb_o);
endmodule

// File: rtl/mdec_rx.sv
module mdec_rx #(
    parameter int OSR         = 8,
    parameter int PRE_EDGES   = 16,
    parameter int SYNC_STAGES = 2,
    parameter int NIB_W       = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_line,
    output logic             rx_dv,
    output logic             nib_stb,
    output logic [NIB_W-1:0] nib_data
);
    localparam int MIN_NIB_GAP = NIB_W * (OSR - OSR / 4);

    logic edge_w, level_w, bit_stb_w, bit_w, locked_w;

    mdec_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .line_i  (rx_line),
        .edge_o  (edge_w),
        .level_o (level_w)
    );

    mdec_bitrec #(.OSR(OSR), .PRE_EDGES(PRE_EDGES)) u_rec (
        .clk       (clk),
        .rst_n     (rst_n),
        .edge_i    (edge_w),
        .level_i   (level_w),
        .locked_o  (locked_w),
        .bit_stb_o (bit_stb_w),
        .bit_o     (bit_w)
    );

    mdec_nibble #(.W(NIB_W), .MIN_GAP(MIN_NIB_GAP)) u_nib (
        .clk       (clk),
        .rst_n     (rst_n),
        .active_i  (locked_w),
        .bit_stb_i (bit_stb_w),
        .bit_i     (bit_w),
        .nib_stb_o (nib_stb),
        .nib_o     (nib_data)
    );

    assign rx_dv = locked_w;

    // R10
    stb_needs_dv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nib_stb |-> rx_dv);
endmodule

// File: tb/sim_mdec_rx.sv
module sim_mdec_rx;
    localparam int OSR = 8;
    localparam int PRE = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_line = 1'b0;
    logic       rx_dv, nib_stb;
    logic [3:0] nib_data;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int last_stb = -1;
    logic [3:0] exp_q[$];
    bit frm[$];
    string tag = "R2 R6";

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mdec_rx #(.OSR(OSR), .PRE_EDGES(PRE)) u0 (
        .clk(clk), .rst_n(rst_n), .rx_line(rx_line),
        .rx_dv(rx_dv), .nib_stb(nib_stb), .nib_data(nib_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && nib_stb) begin
            check(rx_dv, "R10 strobe without valid", rx_dv, 1);
            if (exp_q.size() == 0) begin
                check(0, "R6 R8 unexpected nibble", nib_data, -1);
            end else begin
                logic [3:0] e;
                e = exp_q.pop_front();
                check(nib_data == e, tag, nib_data, e);
            end
            if (last_stb >= 0)
                check(cyc - last_stb == 4 * OSR, "R7 nibble spacing", cyc - last_stb, 4 * OSR);
            last_stb = cyc;
        end
        if (!rx_dv) last_stb = -1;
    end

    task automatic send_bit(input bit b);
        rx_line = ~b;
        repeat (OSR / 2) @(negedge clk);
        rx_line = b;
        repeat (OSR / 2) @(negedge clk);
    endtask

    task automatic add_pre(input int n);
        for (int i = 0; i < n; i++) frm.push_back(bit'(~i[0]));
    endtask

    task automatic add_rand(input int n);
        for (int i = 0; i < n; i++) frm.push_back(bit'($urandom_range(0, 1)));
    endtask

    task automatic send(input bit locks, input string t);
        tag = t;
        if (locks) begin
            for (int i = PRE; i + 3 < frm.size(); i += 4)
                exp_q.push_back({frm[i+3], frm[i+2], frm[i+1], frm[i]});
        end
        for (int i = 0; i < frm.size(); i++) begin
            if (i == PRE + 2 && locks)
                check(rx_dv == 1'b1, "R4 valid after preamble", rx_dv, 1);
            send_bit(frm[i]);
        end
        if (!locks) check(rx_dv == 1'b0, "R3 no lock", rx_dv, 0);
        rx_line = 1'b0;
        repeat (5 * OSR) @(negedge clk);
        check(rx_dv == 1'b0, "R8 valid dropped", rx_dv, 0);
        check(exp_q.size() == 0, "R6 R8 nibbles delivered", exp_q.size(), 0);
        exp_q.delete();
        frm.delete();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        check(0, "watchdog", cyc, 200000);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rx_dv == 1'b0, "R1 rx_dv", rx_dv, 0);
        check(nib_stb == 1'b0, "R1 nib_stb", nib_stb, 0);
        check(nib_data == 4'd0, "R1 nib_data", nib_data, 0);
        repeat (20) @(negedge clk);

        // R2 R4 R5 R6: full preamble, delimiter, 32 random bits (equal-bit runs give boundary edges)
        add_pre(56); frm.push_back(1); frm.push_back(0); frm.push_back(1); frm.push_back(0);
        frm.push_back(1); frm.push_back(0); frm.push_back(1); frm.push_back(1);
        add_rand(32);
        send(1'b1, "R2 R5 R6 frame1");

        // R8: 30 data bits, last 2 bits form a partial nibble that must vanish
        add_pre(64); add_rand(30);
        send(1'b1, "R8 R9 frame2");

        // R3: preamble too short
        add_pre(PRE - 4);
        send(1'b0, "R3 short");

        // R3: run of ones, transitions 4 samples apart
        for (int i = 0; i < 40; i++) frm.push_back(1'b1);
        send(1'b0, "R3 ones");

        // R9: relock after non-locking traffic, all-zero then random data
        add_pre(60); for (int i = 0; i < 16; i++) frm.push_back(1'b0); add_rand(48);
        send(1'b1, "R2 R9 frame3");

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule